// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block moves data words from one clock domain to another in strict arrival order. The producer writes on its own clock. The consumer reads on an unrelated clock. Each side has two enables, and a transfer happens only when both enables of that side are high at its clock edge. Each side tracks its own view of occupancy. It does this by comparing its local binary pointer with the other side's pointer, which arrives Gray-coded through a synchronizer chain. From that view it drives a plain flag and an active-low threshold flag: empty and almost-empty on the read side, full and almost-full on the write side.

The two thresholds are separate offset registers, each held in the domain of the flag that uses it. Both come out of reset at 7. A one-cycle load strobe on each side replaces the offset, but only while that side sees the FIFO as empty. Read data is registered. Storage depth (a power of two), word width and synchronizer length are parameters.

Top module: `async_thresh_fifo`

## Requirements
- R1: A write takes place only when `wr_en_a` and `wr_en_b` are both 1 at a rising `wr_clk` edge while `full` is 0. A read takes place only when `rd_en_a` and `rd_en_b` are both 1 at a rising `rd_clk` edge while `empty` is 0. With one enable low, the edge moves no data.
- R2: Words come out in the order they were written. `rd_data` takes the word of a read at that read's `rd_clk` edge, so it is visible in the cycle after the edge. Between reads it holds its value.
- R3: A write attempted while `full` is 1 is ignored. No stored word is overwritten, and the write pointer does not move.
- R4: A read attempted while `empty` is 1 is ignored. `rd_data` and the read pointer do not change.
- R5: `empty` is 1 when the read-side occupancy is 0. `full` is 1 when the write-side occupancy equals DEPTH. Each flag is registered in its own domain and is updated by the edge that performs the access.
- R6: `almost_empty_n` is 0 exactly when the read-side occupancy is at most the empty offset n. A read that brings the occupancy from n+1 to n drives it to 0 at that read's edge.
- R7: `almost_full_n` is 0 exactly when the write-side occupancy is at least DEPTH−m, where m is the full offset. A write that brings the occupancy from DEPTH−m−1 to DEPTH−m drives it to 0 at that write's edge.
- R8: Each flag changes only on its own clock. A write is first counted by the read-side flags at the third `rd_clk` edge after it. A read is first counted by the write-side flags at the third `wr_clk` edge after it. Pointers cross domains in Gray code, so one bit changes per step.
- R9: Both offsets reset to 7. `ae_load` copies `ae_value` into n only while `empty` is 1. `af_load` copies `af_value` into m only while the write-side occupancy is 0. A load strobe at any other time has no effect.
- R10: After reset: `empty`=1, `full`=0, `almost_empty_n`=0, `almost_full_n`=1, `rd_data`=0, and both pointers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_en_a | input | 1 | Write enable, first of two |
| wr_en_b | input | 1 | Write enable, second of two |
| wr_data | input | DATA_W | Word to store |
| af_load | input | 1 | Load strobe for the full offset |
| af_value | input | log2(DEPTH)+1 | New full offset m |
| full | output | 1 | FIFO full (write domain) |
| almost_full_n | output | 1 | Active-low almost-full threshold flag |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_en_a | input | 1 | Read enable, first of two |
| rd_en_b | input | 1 | Read enable, second of two |
| rd_data | output | DATA_W | Registered read word |
| ae_load | input | 1 | Load strobe for the empty offset |
| ae_value | input | log2(DEPTH)+1 | New empty offset n |
| empty | output | 1 | FIFO empty (read domain) |
| almost_empty_n | output | 1 | Active-low almost-empty threshold flag |

## Verification
The bench runs several kinds of traffic against the flags. It pushes twenty words into a sixteen-deep FIFO, reads past empty, strobes a single enable, and tries offset loads while the FIFO holds data. A design that overwrote when full would return lost or corrupt words. One that read when empty would repeat a word on `rd_data`. A flag computed one access late, or from the unsynchronized remote pointer, shows up because the bench compares both threshold flags on every edge against a model that delays remote activity by exactly two stages. Random offsets, including zero and DEPTH, are loaded during write-heavy and read-heavy bursts. These catch off-by-one threshold comparisons and loads accepted while the FIFO was not empty.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
   localparam int unsigned OFFSET_RESET = 7;
   localparam int unsigned MAX_PTR_W    = 32;

   function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction
endpackage

// File: rtl/tfifo_sync.sv
module tfifo_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= stage[g-1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/tfifo_ram.sv
module tfifo_ram #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned AW     = 4
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned WORDS = 1 << AW;

   logic [DATA_W-1:0] store [WORDS];

   always_ff @(posedge wr_clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) rdata <= '0;
      else if (re)   rdata <= store[raddr];
   end
endmodule

// File: rtl/tfifo_wr_side.sv
module tfifo_wr_side
   import tfifo_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_a,
   input  logic          en_b,
   input  logic [AW:0]   rgray_sync,
   input  logic          ld,
   input  logic [AW:0]   ld_value,
   output logic          we,
   output logic [AW:0]   ptr,
   output logic [AW:0]   gray,
   output logic          full,
   output logic          almost_full_n
);
   localparam int unsigned PW    = AW + 1;
   localparam logic [PW:0] LIMIT = (PW+1)'(1 << AW);

   logic [PW-1:0] ptr_nx, rptr_bin, occ_now, occ_nx, m_off;
   logic [PW:0]   reach;

   assign we       = en_a & en_b & ~full;
   assign ptr_nx   = ptr + PW'(we);
   assign rptr_bin = PW'(gray_to_bin(32'(rgray_sync)));
   assign occ_now  = ptr - rptr_bin;
   assign occ_nx   = ptr_nx - rptr_bin;
   assign reach    = {1'b0, occ_nx} + {1'b0, m_off};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr           <= '0;
         gray          <= '0;
         full          <= 1'b0;
         almost_full_n <= 1'b1;
         m_off         <= PW'(OFFSET_RESET);
      end else begin
         ptr           <= ptr_nx;
         gray          <= PW'(bin_to_gray(32'(ptr_nx)));
         full          <= ({1'b0, occ_nx} == LIMIT);
         almost_full_n <= (reach < LIMIT);
         if (ld && occ_now == '0) m_off <= ld_value;
      end
   end
endmodule

// File: rtl/tfifo_rd_side.sv
module tfifo_rd_side
   import tfifo_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_a,
   input  logic          en_b,
   input  logic [AW:0]   wgray_sync,
   input  logic          ld,
   input  logic [AW:0]   ld_value,
   output logic          re,
   output logic [AW:0]   ptr,
   output logic [AW:0]   gray,
   output logic          empty,
   output logic          almost_empty_n
);
   localparam int unsigned PW = AW + 1;

   logic [PW-1:0] ptr_nx, wptr_bin, occ_nx, n_off;

   assign re       = en_a & en_b & ~empty;
   assign ptr_nx   = ptr + PW'(re);
   assign wptr_bin = PW'(gray_to_bin(32'(wgray_sync)));
   assign occ_nx   = wptr_bin - ptr_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr            <= '0;
         gray           <= '0;
         empty          <= 1'b1;
         almost_empty_n <= 1'b0;
         n_off          <= PW'(OFFSET_RESET);
      end else begin
         ptr            <= ptr_nx;
         gray           <= PW'(bin_to_gray(32'(ptr_nx)));
         empty          <= (occ_nx == '0);
         almost_empty_n <= (occ_nx > n_off);
         if (ld && empty) n_off <= ld_value;
      end
   end
endmodule

// File: rtl/async_thresh_fifo.sv
module async_thresh_fifo
   import tfifo_pkg::*;
#(
   parameter int unsigned DEPTH       = 1024,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                      wr_clk,
   input  logic                      wr_rst_n,
   input  logic                      wr_en_a,
   input  logic                      wr_en_b,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      af_load,
   input  logic [$clog2(DEPTH):0]    af_value,
   output logic                      full,
   output logic                      almost_full_n,
   input  logic                      rd_clk,
   input  logic                      rd_rst_n,
   input  logic                      rd_en_a,
   input  logic                      rd_en_b,
   output logic [DATA_W-1:0]         rd_data,
   input  logic                      ae_load,
   input  logic [$clog2(DEPTH):0]    ae_value,
   output logic                      empty,
   output logic                      almost_empty_n
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 4");
   end
   if (PW > MAX_PTR_W) begin : g_bad_ptr
      $error("pointer width exceeds the conversion helpers");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic          wr_fire, rd_fire;
   logic [PW-1:0] wr_ptr, rd_ptr, wr_gray, rd_gray, wr_gray_s, rd_gray_s;

   tfifo_wr_side #(.AW(AW)) u_wr (
      .clk(wr_clk), .rst_n(wr_rst_n), .en_a(wr_en_a), .en_b(wr_en_b),
      .rgray_sync(rd_gray_s), .ld(af_load), .ld_value(af_value),
      .we(wr_fire), .ptr(wr_ptr), .gray(wr_gray),
      .full(full), .almost_full_n(almost_full_n)
   );

   tfifo_rd_side #(.AW(AW)) u_rd (
      .clk(rd_clk), .rst_n(rd_rst_n), .en_a(rd_en_a), .en_b(rd_en_b),
      .wgray_sync(wr_gray_s), .ld(ae_load), .ld_value(ae_value),
      .re(rd_fire), .ptr(rd_ptr), .gray(rd_gray),
      .empty(empty), .almost_empty_n(almost_empty_n)
   );

   tfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s)
   );

   tfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s)
   );

   tfifo_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
      .wr_clk(wr_clk), .we(wr_fire), .waddr(wr_ptr[AW-1:0]), .wdata(wr_data),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .re(rd_fire),
      .raddr(rd_ptr[AW-1:0]), .rdata(rd_data)
   );
endmodule

// File: rtl/tfifo_checker.sv
module tfifo_checker #(
   parameter int unsigned PW     = 5,
   parameter int unsigned DATA_W = 16
) (
   input logic              wr_clk,
   input logic              wr_rst_n,
   input logic              wr_en_a,
   input logic              wr_en_b,
   input logic              full,
   input logic              almost_full_n,
   input logic              rd_clk,
   input logic              rd_rst_n,
   input logic              rd_en_a,
   input logic              rd_en_b,
   input logic              empty,
   input logic              almost_empty_n,
   input logic [DATA_W-1:0] rd_data,
   input logic [PW-1:0]     wr_ptr,
   input logic [PW-1:0]     rd_ptr,
   input logic [PW-1:0]     wr_gray
);
   p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      full |=> wr_ptr == $past(wr_ptr));

   p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      empty |=> rd_ptr == $past(rd_ptr));

   p_wr_step_r1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_ptr != $past(wr_ptr)) |->
         ($past(wr_en_a && wr_en_b && !full) && wr_ptr == $past(wr_ptr) + 1'b1));

   p_rd_step_r1: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_ptr != $past(rd_ptr)) |->
         ($past(rd_en_a && rd_en_b && !empty) && rd_ptr == $past(rd_ptr) + 1'b1));

   p_full_implies_af_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      full |-> !almost_full_n);

   p_empty_implies_ae_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      empty |-> !almost_empty_n);

   p_gray_one_bit_r8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $onehot0(wr_gray ^ $past(wr_gray)));

   p_rdata_hold_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      !(rd_en_a && rd_en_b && !empty) |=> $stable(rd_data));
endmodule

bind async_thresh_fifo tfifo_checker #(.PW(AW + 1), .DATA_W(DATA_W)) u_chk (
   .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
   .full(full), .almost_full_n(almost_full_n),
   .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
   .empty(empty), .almost_empty_n(almost_empty_n), .rd_data(rd_data),
   .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_gray(wr_gray)
);

// File: tb/test_async_thresh_fifo.sv
module test_async_thresh_fifo;
   localparam int DEPTH  = 16;
   localparam int DATA_W = 16;
   localparam int OW     = $clog2(DEPTH) + 1;

   logic              wr_clk = 1'b0, rd_clk = 1'b0;
   logic              wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic              wr_en_a = 0, wr_en_b = 0, rd_en_a = 0, rd_en_b = 0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              af_load = 0, ae_load = 0;
   logic [OW-1:0]     af_value = '0, ae_value = '0;
   logic              full, almost_full_n, empty, almost_empty_n;
   logic [DATA_W-1:0] rd_data;

   int n_cmp = 0, n_bad = 0;
   bit checking = 0;

   async_thresh_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SYNC_STAGES(2)) i_async_thresh_fifo (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
      .wr_data(wr_data), .af_load(af_load), .af_value(af_value),
      .full(full), .almost_full_n(almost_full_n),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
      .rd_data(rd_data), .ae_load(ae_load), .ae_value(ae_value),
      .empty(empty), .almost_empty_n(almost_empty_n)
   );

   initial forever #2 wr_clk = ~wr_clk;
   initial begin #1; forever #2 rd_clk = ~rd_clk; end

   // behavioural reference: counts, a word queue and two-stage visibility delays
   logic [DATA_W-1:0] q[$];
   int wcnt, rcnt, s1, s2, ws1, ws2, m_off, n_off;
   bit exp_full, exp_af_n, exp_empty, exp_ae_n;
   logic [DATA_W-1:0] exp_rd;

   always @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         q.delete(); wcnt = 0; s1 = 0; s2 = 0; m_off = 7;
         exp_full = 0; exp_af_n = 1;
      end else begin
         int occ_old, occ;
         occ_old = wcnt - s2;
         if (wr_en_a && wr_en_b && !exp_full) begin q.push_back(wr_data); wcnt++; end
         occ = wcnt - s2;
         exp_full = (occ == DEPTH);
         exp_af_n = !(occ + m_off >= DEPTH);
         if (af_load && occ_old == 0) m_off = int'(af_value);
         s2 = s1; s1 = rcnt;
      end
   end

   always @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rcnt = 0; ws1 = 0; ws2 = 0; n_off = 7;
         exp_empty = 1; exp_ae_n = 0; exp_rd = '0;
      end else begin
         int occ;
         bit was_empty;
         was_empty = exp_empty;
         if (rd_en_a && rd_en_b && !exp_empty) begin exp_rd = q.pop_front(); rcnt++; end
         occ = ws2 - rcnt;
         exp_empty = (occ == 0);
         exp_ae_n = !(occ <= n_off);
         if (ae_load && was_empty) n_off = int'(ae_value);
         ws2 = ws1; ws1 = wcnt;
      end
   end

   task automatic cmp(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge wr_clk) if (checking) begin
      cmp(64'(full), 64'(exp_full), "R5 R3 R8 full");
      cmp(64'(almost_full_n), 64'(exp_af_n), "R7 R8 R9 almost_full_n");
   end

   always @(negedge rd_clk) if (checking) begin
      cmp(64'(empty), 64'(exp_empty), "R5 R4 R8 empty");
      cmp(64'(almost_empty_n), 64'(exp_ae_n), "R6 R8 R9 almost_empty_n");
      cmp(64'(rd_data), 64'(exp_rd), "R1 R2 R3 R4 rd_data");
   end

   task automatic wr_burst(input int cycles, input bit a, input bit b);
      for (int i = 0; i < cycles; i++) begin
         @(negedge wr_clk);
         wr_en_a = a; wr_en_b = b; wr_data = DATA_W'($urandom);
      end
      @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0;
   endtask

   task automatic rd_burst(input int cycles, input bit a, input bit b);
      for (int i = 0; i < cycles; i++) begin
         @(negedge rd_clk); rd_en_a = a; rd_en_b = b;
      end
      @(negedge rd_clk); rd_en_a = 0; rd_en_b = 0;
   endtask

   task automatic load_both(input int af, input int ae);
      @(negedge wr_clk); af_load = 1; af_value = OW'(af);
      @(negedge wr_clk); af_load = 0;
      @(negedge rd_clk); ae_load = 1; ae_value = OW'(ae);
      @(negedge rd_clk); ae_load = 0;
   endtask

   task automatic random_traffic(input int cycles, input int wr_pct, input int rd_pct);
      fork
         for (int i = 0; i < cycles; i++) begin
            @(negedge wr_clk);
            wr_en_a = ($urandom_range(99) < wr_pct) ? 1'b1 : 1'b0;
            wr_en_b = ($urandom_range(9) != 0) ? 1'b1 : 1'b0;
            wr_data = DATA_W'($urandom);
            af_load = ($urandom_range(15) == 0) ? 1'b1 : 1'b0;
            af_value = OW'($urandom_range(DEPTH));
         end
         for (int i = 0; i < cycles; i++) begin
            @(negedge rd_clk);
            rd_en_a = ($urandom_range(99) < rd_pct) ? 1'b1 : 1'b0;
            rd_en_b = ($urandom_range(9) != 0) ? 1'b1 : 1'b0;
            ae_load = ($urandom_range(15) == 0) ? 1'b1 : 1'b0;
            ae_value = OW'($urandom_range(DEPTH));
         end
      join
      @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0; af_load = 0;
      @(negedge rd_clk); rd_en_a = 0; rd_en_b = 0; ae_load = 0;
   endtask

   task automatic idle(input int cycles);
      repeat (cycles) @(negedge wr_clk);
   endtask

   initial begin
      #(400000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished at %0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge wr_clk);
      wr_rst_n = 1; rd_rst_n = 1;
      #0.5;
      // R10: reset state
      cmp(64'(empty), 64'd1, "R10 empty");
      cmp(64'(full), 64'd0, "R10 full");
      cmp(64'(almost_empty_n), 64'd0, "R10 almost_empty_n");
      cmp(64'(almost_full_n), 64'd1, "R10 almost_full_n");
      cmp(64'(rd_data), 64'd0, "R10 rd_data");
      checking = 1;
      // R9: default offsets of 7 exercised first
      wr_burst(9, 1, 1);  idle(12);
      rd_burst(12, 1, 1); idle(12);
      // R9: loads accepted while empty
      load_both(4, 3);    idle(6);
      // R1: a single enable moves nothing
      wr_burst(4, 1, 0); wr_burst(4, 0, 1); idle(10);
      // R3 R5 R7: overfill a DEPTH-deep FIFO
      wr_burst(DEPTH + 4, 1, 1); idle(12);
      // R9: loads while holding data must be ignored
      load_both(10, 10); idle(6);
      // R1 R4 R6: single-enable reads, then drain past empty
      rd_burst(4, 0, 1); rd_burst(DEPTH + 6, 1, 1); idle(12);
      // edge offsets: m=0 and n=0, then n=DEPTH and m=DEPTH
      load_both(0, 0);  wr_burst(DEPTH + 2, 1, 1); idle(10); rd_burst(DEPTH + 2, 1, 1); idle(12);
      load_both(DEPTH, DEPTH); wr_burst(3, 1, 1); idle(10); rd_burst(5, 1, 1); idle(12);
      // R8: random mixes, write-heavy and read-heavy
      random_traffic(2500, 80, 40); idle(10);
      rd_burst(DEPTH + 8, 1, 1); idle(12);
      random_traffic(2500, 35, 85); idle(10);
      rd_burst(DEPTH + 8, 1, 1); idle(12);
      checking = 0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule